// File: doc/BRIEF.md
# Three-Stage Instruction Sequencer with Decode-Time Address Formation

This block steps a stream of program words through fetch, decode and execute, one clock per stage slot. It accepts words on a valid/ready port and presents the address of the next word it wants. Every instruction fills one slot in each stage, and a new one-word instruction may follow in the very next cycle. A two-word instruction takes its second word as an extension operand and spends two cycles in execute.

Data-memory targets are resolved while an instruction sits in decode. A mode register chooses the data map: with its ROM-enable bit set, low addresses go to internal ROM, and everything else goes to external RAM. Mode and condition-code writes commit at the end of the execute slot. A load decoded in the same cycle therefore still sees the old map. A conditional jump, which reads the flags in its own execute slot, already sees the new flags. Both behaviours are deliberate and carry no interlock.

The port rules are as follows. `pw_ready` is low in reset and in the first cycle after release, and high from then on; the block never applies back-pressure. A word is taken on any cycle with both `pw_valid` and `pw_ready` high. If the source drops `pw_valid`, a bubble enters the pipeline, or, when an extension word is due, the decode stage waits for it.

Top module: `pipe3_seq`

## Requirements
- R1: Reset clears the stage flags, the mode register and `ccr`. `pw_ready` is low during reset and in the first cycle after release, and the first word fetched after that cycle is taken from address 0.
- R2: A word accepted in cycle c as an opcode is in decode in cycle c+1 and in execute in cycle c+2. Back-to-back words give one instruction per cycle.
- R3: The word accepted right after a long-load opcode is its extension and is never decoded. The long load occupies execute for two consecutive cycles and retires in the second one.
- R4: While a long load in decode waits for its extension, the decode flag stays high, execute receives a bubble and the waiting opcode is held unchanged.
- R5: Word encoding: bits [15:12] are the opcode. 0 is a no-op; 1 ORs bits [7:0] into the mode register; 2 ORs bits [7:0] into the condition codes; 3 is a short load from address bits [11:0]; 4 is a long load whose address is the whole extension word; 5 is a conditional jump testing condition-code bit [11:9] with target bits [8:0]. Every other opcode behaves as a no-op.
- R6: A load targets ROM (`mem_rom`=1) exactly when mode bit 2 is set in the cycle its address is decoded and the address is below 256. Otherwise it targets external RAM.
- R7: A mode OR takes effect at the end of its execute slot. A load fetched directly after it uses the old map, and a load with one instruction between them uses the new map.
- R8: A condition-code OR takes effect at the end of its execute slot. A jump directly after it reports `br_taken` equal to the updated flag bit it names.
- R9: `mem_valid`, `mem_rom` and `mem_addr` are presented in the retiring execute cycle of a load. For a long load, that is the second execute cycle.
- R10: The fetch address advances by one for every accepted word, extension words included, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | output | 16 | Address of the program word requested |
| pw_valid | input | 1 | Program word present |
| pw_data | input | 16 | Program word |
| pw_ready | output | 1 | Block takes a word this cycle |
| stg_fetch | output | 1 | A word is fetched this cycle |
| stg_decode | output | 1 | Decode slot occupied |
| stg_exec | output | 1 | Execute slot occupied |
| retire | output | 1 | An instruction finishes execute this cycle |
| mem_valid | output | 1 | Data access presented |
| mem_rom | output | 1 | Access targets internal ROM (else external RAM) |
| mem_addr | output | 16 | Data access address |
| br_valid | output | 1 | Conditional jump resolves this cycle |
| br_taken | output | 1 | Jump condition true |
| br_target | output | 9 | Jump target |
| ccr | output | 8 | Condition-code register |

## Verification
The map hazard is tried three ways: a mode OR followed directly by a load, the same pair with a no-op between them, and a load above the ROM range with the bit set. Together these separate decode-time sampling from execute-time sampling and from the range limit. A flag OR followed at once by jumps on a set bit and on a clear bit shows that flag writes are visible without delay. A long load is run with its extension withheld for several cycles to expose stalling and operand routing. A long mixed stream with irregular valid gaps and every opcode value, compared every cycle against a behavioural model, covers bubbles, unknown opcodes and back-to-back two-word sequences.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;
  localparam int WORD_W  = 16;
  localparam int OP_W    = 4;
  localparam int IMM_W   = 8;
  localparam int SADDR_W = 12;
  localparam int COND_W  = 3;
  localparam int TGT_W   = 9;
  localparam int CC_W    = IMM_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 4'd0,
    OP_ORM = 4'd1,
    OP_ORC = 4'd2,
    OP_LDS = 4'd3,
    OP_LDL = 4'd4,
    OP_JCC = 4'd5
  } op_e;

  typedef struct packed {
    logic              valid;
    op_e               op;
    logic [IMM_W-1:0]  imm;
    logic              two;
    logic              rom;
    logic [WORD_W-1:0] addr;
    logic [COND_W-1:0] cond;
    logic [TGT_W-1:0]  tgt;
  } dec_pkt_t;

  function automatic op_e op_of(input logic [WORD_W-1:0] w);
    case (w[WORD_W-1 -: OP_W])
      4'd1:    return OP_ORM;
      4'd2:    return OP_ORC;
      4'd3:    return OP_LDS;
      4'd4:    return OP_LDL;
      4'd5:    return OP_JCC;
      default: return OP_NOP;
    endcase
  endfunction
endpackage

// File: rtl/pipe3_fetch.sv
module pipe3_fetch
  import pipe3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pw_valid,
  output logic              pw_ready,
  output logic              hs,
  output logic [WORD_W-1:0] pc
);
  logic go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go <= 1'b0;
      pc <= '0;
    end else begin
      go <= 1'b1;
      if (hs) pc <= pc + 1'b1;
    end
  end

  assign pw_ready = go;
  assign hs       = pw_valid && go;

  assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> pc == $past(pc) + 1'b1);
  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> $stable(pc));
endmodule

// File: rtl/pipe3_decode.sv
module pipe3_decode
  import pipe3_pkg::*;
#(
  parameter int ROM_DEPTH = 256,
  parameter int ROM_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs,
  input  logic [WORD_W-1:0] pw_data,
  input  logic [CC_W-1:0]   mode,
  output logic              dec_v,
  output dec_pkt_t          pkt
);
  localparam logic [WORD_W-1:0] ROM_LIM = WORD_W'(ROM_DEPTH);

  logic [WORD_W-1:0] dec_word;
  logic              is_two, wait_ext, take_ext;
  logic [WORD_W-1:0] addr;

  assign is_two   = op_of(dec_word) == OP_LDL;
  assign wait_ext = dec_v && is_two && !hs;
  assign take_ext = dec_v && is_two && hs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_v    <= 1'b0;
      dec_word <= '0;
    end else if (!wait_ext) begin
      dec_v <= hs && !take_ext;
      if (hs && !take_ext) dec_word <= pw_data;
    end
  end

  // address formed here, with the map in force during this decode cycle
  assign addr = is_two ? pw_data
                       : {{(WORD_W-SADDR_W){1'b0}}, dec_word[SADDR_W-1:0]};

  always_comb begin
    pkt       = '0;
    pkt.valid = dec_v && !wait_ext;
    pkt.op    = op_of(dec_word);
    pkt.imm   = dec_word[IMM_W-1:0];
    pkt.two   = is_two;
    pkt.addr  = addr;
    pkt.rom   = mode[ROM_BIT] && (addr < ROM_LIM);
    pkt.cond  = dec_word[TGT_W +: COND_W];
    pkt.tgt   = dec_word[TGT_W-1:0];
  end

  assert_ext_not_opcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_ext |=> !dec_v);
  assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ext |=> dec_v && $stable(dec_word));
endmodule

// File: rtl/pipe3_execute.sv
module pipe3_execute
  import pipe3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dec_pkt_t          pkt,
  output logic              exe_v,
  output logic              retire,
  output logic              mem_valid,
  output logic              mem_rom,
  output logic [WORD_W-1:0] mem_addr,
  output logic              br_valid,
  output logic              br_taken,
  output logic [TGT_W-1:0]  br_target,
  output logic [CC_W-1:0]   mode,
  output logic [CC_W-1:0]   cc
);
  dec_pkt_t ex;
  logic     ph1, first_two, final_slot;

  assign first_two  = ex.valid && ex.two && !ph1;
  assign final_slot = ex.valid && !first_two;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex   <= '0;
      ph1  <= 1'b0;
      mode <= '0;
      cc   <= '0;
    end else begin
      if (first_two) begin
        ph1 <= 1'b1;
      end else begin
        ex  <= pkt;
        ph1 <= 1'b0;
      end
      if (final_slot && ex.op == OP_ORM) mode <= mode | ex.imm;
      if (final_slot && ex.op == OP_ORC) cc   <= cc | ex.imm;
    end
  end

  assign exe_v     = ex.valid;
  assign retire    = final_slot;
  assign mem_valid = final_slot && (ex.op == OP_LDS || ex.op == OP_LDL);
  assign mem_rom   = ex.rom;
  assign mem_addr  = ex.addr;
  assign br_valid  = final_slot && ex.op == OP_JCC;
  assign br_taken  = br_valid && cc[ex.cond];
  assign br_target = ex.tgt;

  assert_decode_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    first_two |-> !pkt.valid);
  assert_second_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    first_two |=> exe_v && retire);
  assert_mode_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (final_slot && ex.op == OP_ORM) |=> mode == ($past(mode) | $past(ex.imm)));
  assert_cc_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (final_slot && ex.op == OP_ORC) |=> cc == ($past(cc) | $past(ex.imm)));
endmodule

// File: rtl/pipe3_seq.sv
module pipe3_seq
  import pipe3_pkg::*;
#(
  parameter int ROM_DEPTH = 256,
  parameter int ROM_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [WORD_W-1:0] fetch_addr,
  input  logic              pw_valid,
  input  logic [WORD_W-1:0] pw_data,
  output logic              pw_ready,
  output logic              stg_fetch,
  output logic              stg_decode,
  output logic              stg_exec,
  output logic              retire,
  output logic              mem_valid,
  output logic              mem_rom,
  output logic [WORD_W-1:0] mem_addr,
  output logic              br_valid,
  output logic              br_taken,
  output logic [TGT_W-1:0]  br_target,
  output logic [CC_W-1:0]   ccr
);
  logic            hs;
  logic [CC_W-1:0] mode;
  dec_pkt_t        pkt;

  pipe3_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid),
    .pw_ready(pw_ready), .hs(hs), .pc(fetch_addr)
  );

  pipe3_decode #(.ROM_DEPTH(ROM_DEPTH), .ROM_BIT(ROM_BIT)) u_decode (
    .clk(clk), .rst_n(rst_n), .hs(hs), .pw_data(pw_data),
    .mode(mode), .dec_v(stg_decode), .pkt(pkt)
  );

  pipe3_execute u_exec (
    .clk(clk), .rst_n(rst_n), .pkt(pkt), .exe_v(stg_exec), .retire(retire),
    .mem_valid(mem_valid), .mem_rom(mem_rom), .mem_addr(mem_addr),
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
    .mode(mode), .cc(ccr)
  );

  assign stg_fetch = hs;

  assert_fetch_is_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stg_fetch |-> pw_ready && pw_valid);
endmodule

// File: tb/sim_pipe3_seq.sv
`timescale 1ns/1ps
module sim_pipe3_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pw_valid = 1'b0;
  logic [15:0] pw_data = '0;
  logic [15:0] fetch_addr, mem_addr;
  logic        pw_ready, stg_fetch, stg_decode, stg_exec, retire;
  logic        mem_valid, mem_rom, br_valid, br_taken;
  logic [8:0]  br_target;
  logic [7:0]  ccr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pipe3_seq u0 (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .pw_valid(pw_valid),
    .pw_data(pw_data), .pw_ready(pw_ready), .stg_fetch(stg_fetch),
    .stg_decode(stg_decode), .stg_exec(stg_exec), .retire(retire),
    .mem_valid(mem_valid), .mem_rom(mem_rom), .mem_addr(mem_addr),
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target), .ccr(ccr)
  );

  // behavioural reference state
  int          cyc;
  bit          m_go;
  int          m_pc;
  bit [7:0]    m_mode, m_cc;
  bit          m_dv;
  bit [15:0]   m_dw;
  bit [15:0]   x_word[int];
  bit          x_fin[int];
  bit          x_rom[int];
  int          x_addr[int];
  bit          romq[$];
  int          addrq[$];
  bit          brq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int opc(input bit [15:0] w);
    return (w[15:12] <= 4'd5) ? int'(w[15:12]) : 0;
  endfunction

  task automatic model_reset();
    cyc = 0; m_go = 0; m_pc = 0; m_mode = 0; m_cc = 0; m_dv = 0; m_dw = 0;
    x_word.delete(); x_fin.delete(); x_rom.delete(); x_addr.delete();
    romq.delete(); addrq.delete(); brq.delete();
  endtask

  task automatic step();
    bit hs, ev, fin, em, eb, used, two, r;
    bit [15:0] w;
    int o, a;
    hs = m_go && pw_valid;
    chk(fetch_addr == m_pc[15:0], "R10 fetch address", fetch_addr, m_pc);
    chk(pw_ready == m_go, "R1 ready", pw_ready, m_go);
    chk(stg_fetch == hs, "R2 fetch flag", stg_fetch, hs);
    chk(stg_decode == m_dv, "R4 decode flag", stg_decode, m_dv);
    ev = x_word.exists(cyc);
    chk(stg_exec == ev, "R2 execute flag", stg_exec, ev);
    fin = ev && x_fin[cyc];
    w = ev ? x_word[cyc] : 16'h0;
    o = opc(w);
    chk(retire == fin, "R3 retire", retire, fin);
    em = fin && (o == 3 || o == 4);
    chk(mem_valid == em, "R9 mem valid", mem_valid, em);
    if (em) begin
      chk(mem_rom == x_rom[cyc], "R6 map target", mem_rom, x_rom[cyc]);
      chk(mem_addr == x_addr[cyc][15:0], "R9 mem address", mem_addr, x_addr[cyc]);
      romq.push_back(mem_rom);
      addrq.push_back(int'(mem_addr));
    end
    eb = fin && o == 5;
    chk(br_valid == eb, "R8 jump valid", br_valid, eb);
    if (eb) begin
      chk(br_taken == m_cc[w[11:9]], "R8 jump taken", br_taken, m_cc[w[11:9]]);
      chk(br_target == w[8:0], "R5 jump target", br_target, w[8:0]);
      brq.push_back(br_taken);
    end
    chk(ccr == m_cc, "R8 ccr", ccr, m_cc);
    // advance model
    used = 0;
    if (m_dv) begin
      two = opc(m_dw) == 4;
      if (!two || hs) begin
        a = two ? int'(pw_data) : int'(m_dw[11:0]);
        r = m_mode[2] && a < 256;
        x_word[cyc+1] = m_dw;
        if (two) begin
          x_fin[cyc+1] = 0;
          x_word[cyc+2] = m_dw; x_fin[cyc+2] = 1;
          x_rom[cyc+2] = r; x_addr[cyc+2] = a;
          used = 1;
        end else begin
          x_fin[cyc+1] = 1; x_rom[cyc+1] = r; x_addr[cyc+1] = a;
        end
        m_dv = 0;
      end
    end
    if (hs && !used) begin
      m_dv = 1; m_dw = pw_data;
    end
    if (fin && o == 1) m_mode |= w[7:0];
    if (fin && o == 2) m_cc |= w[7:0];
    if (hs) m_pc++;
    m_go = 1;
    cyc++;
  endtask

  task automatic drive(input bit v, input bit [15:0] d);
    @(negedge clk);
    pw_valid = v; pw_data = d;
    #1;
    step();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pw_valid = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(pw_ready == 0, "R1 ready low in reset", pw_ready, 0);
    chk({stg_fetch, stg_decode, stg_exec} == 3'b000, "R1 stage flags", {stg_fetch, stg_decode, stg_exec}, 0);
    chk(ccr == 0, "R1 ccr cleared", ccr, 0);
    model_reset();
    rst_n = 1;
    step();
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 16'h0);
  endtask

  initial begin
    bit [15:0] lfsr;
    // R7: stale map directly after mode OR
    do_reset();
    drive(1, 16'h1004);
    chk(fetch_addr == 16'h0, "R1 first fetch address", fetch_addr, 0);
    drive(1, 16'h3010);
    flush(4);
    chk(romq.size() == 1 && romq[0] == 0, "R7 load after mode OR uses old map", romq.size() ? romq[0] : 9, 0);

    // R7 / R6: one slot between, then an address above the ROM range
    do_reset();
    drive(1, 16'h1004); drive(1, 16'h0000); drive(1, 16'h3010); drive(1, 16'h3120);
    flush(4);
    chk(romq.size() == 2 && romq[0] == 1, "R7 load after gap uses new map", romq.size() ? romq[0] : 9, 1);
    chk(romq.size() == 2 && romq[1] == 0, "R6 address above ROM goes external", romq.size() > 1 ? romq[1] : 9, 0);

    // R8: flag OR visible to the next jump
    do_reset();
    drive(1, 16'h2002); drive(1, 16'h5255); drive(1, 16'h56AA);
    flush(4);
    chk(brq.size() == 2 && brq[0] == 1, "R8 jump on fresh flag taken", brq.size() ? brq[0] : 9, 1);
    chk(brq.size() == 2 && brq[1] == 0, "R8 jump on clear flag not taken", brq.size() > 1 ? brq[1] : 9, 0);

    // R3 / R4 / R9: long load with its extension withheld
    do_reset();
    drive(1, 16'h1004); drive(1, 16'h0000); drive(1, 16'h4000);
    drive(0, 16'hFFFF); drive(0, 16'hFFFF);
    drive(1, 16'h0020); drive(1, 16'h0000);
    flush(5);
    chk(addrq.size() == 1 && addrq[0] == 32'h20, "R3 extension word used as address", addrq.size() ? addrq[0] : -1, 32'h20);
    chk(romq.size() == 1 && romq[0] == 1, "R9 long load target", romq.size() ? romq[0] : 9, 1);

    // R5: undefined opcode changes nothing
    do_reset();
    drive(1, 16'hF0FF); drive(1, 16'h70FF);
    flush(4);
    chk(ccr == 8'h00, "R5 undefined opcode leaves ccr", ccr, 0);
    chk(romq.size() == 0, "R5 undefined opcode makes no access", romq.size(), 0);

    // mixed stream with irregular valid
    do_reset();
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[3], {lfsr[7:4] ^ lfsr[11:8], lfsr[11:0]});
    end
    flush(6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule